// File: doc/BRIEF.md
# Discharge Short-Circuit Fault Supervisor

This block is the digital side of discharge short-circuit protection in a battery monitor. An analog comparator outside the block reports that the sense-resistor voltage is above the selected threshold. The block synchronizes that flag and raises an early warning. When the condition lasts for the configured trip delay, it declares a fault and asks the FET drivers to turn the discharge and/or charge FETs off.

After a fault, the block releases by itself once the comparator has stayed quiet for a programmed number of seconds. Software can choose manual release instead, in which case a host strobe clears the fault. Each trip increments a retry counter. When the counter reaches a configured limit, both FETs are locked off until a dedicated latch-clear strobe or a reset. A run of five fault-free seconds returns the counter to zero.

Time is measured with two externally generated single-cycle ticks, one every 15 µs and one every second.

Top module: `scp_fault_ctrl`

## Requirements
- R1: With `en_i` low, neither `alert_o` nor `fault_o` rises, whatever the comparator does.
- R2: `alert_o` is high while the synchronized comparator flag is high and no fault is set. It falls when the flag falls before a trip.
- R3: With delay code 0, `fault_o` sets on the clock after the first synchronized high sample. `alert_o` falls on that same clock.
- R4: With delay code n (1..10), the trip happens on the 2^(n-1)-th 15 µs tick counted while the flag is continuously high. The count restarts if the flag drops. Codes 11..15 behave as code 10 (512 ticks).
- R5: Every trip increments the retry counter by one, saturating at its maximum.
- R6: While `fault_o` is high, `dsg_off_o` follows `dsg_auto_i` and `chg_off_o` follows `chg_auto_i`. Both are low when there is no fault and no latch.
- R7: With a nonzero recovery time T, the fault clears on the T-th 1 s tick counted while the flag is continuously low. A high flag restarts the count.
- R8: With recovery time 0, second ticks never clear the fault and a `host_rec_i` pulse does. With a nonzero recovery time, `host_rec_i` is ignored.
- R9: When a trip brings the counter to a value ≥ `latch_lim_i`, `latched_o` sets. While `latched_o` is set, both off requests are high and neither timed nor host recovery clears the fault.
- R10: The retry counter returns to zero after 5 consecutive 1 s ticks with no fault. With fewer ticks, the counter is kept.
- R11: A `latch_clr_i` pulse clears `latched_o` and the retry counter. The fault then recovers normally.
- R12: The comparator input passes through two flip-flops. `alert_o` rises two clocks after `cmp_raw_i` rises and falls two clocks after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmp_raw_i | input | 1 | Asynchronous comparator flag, high means over threshold |
| en_i | input | 1 | Protection enable |
| dly_code_i | input | 4 | Trip delay code |
| rec_time_i | input | 8 | Recovery time in seconds, 0 = manual |
| latch_lim_i | input | CNT_W | Retry count that locks the FETs off |
| dsg_auto_i | input | 1 | Fault turns discharge FET off |
| chg_auto_i | input | 1 | Fault turns charge FET off |
| host_rec_i | input | 1 | Host recovery strobe |
| latch_clr_i | input | 1 | Latch and counter clear strobe |
| tick15_i | input | 1 | One-cycle pulse every 15 µs |
| tick1s_i | input | 1 | One-cycle pulse every second |
| alert_o | output | 1 | Over-threshold warning before trip |
| fault_o | output | 1 | Fault status |
| latched_o | output | 1 | Retry limit reached, FETs locked off |
| dsg_off_o | output | 1 | Discharge FET off request |
| chg_off_o | output | 1 | Charge FET off request |

## Verification
A trip-delay counter that is off by one, or that fails to restart, shows as `fault_o` rising one 15 µs tick early or late. The bench counts ticks exactly around each boundary, so the error appears on the tick in question. A recovery or quiet counter that is miscounted shows on the first 1 s tick at which `fault_o` should fall or fail to fall, or at the next trip, where `latched_o` comes out wrong. A broken synchronizer shows as `alert_o` moving one clock early or late.

// File: rtl/scp_fault_ctrl.sv
module scp_fault_ctrl #(
  parameter int CNT_W    = 4,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 10,
  parameter int QUIET_S  = 5
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic             cmp_raw_i,
  input  logic             en_i,
  input  logic [CODE_W-1:0] dly_code_i,
  input  logic [7:0]       rec_time_i,
  input  logic [CNT_W-1:0] latch_lim_i,
  input  logic             dsg_auto_i,
  input  logic             chg_auto_i,
  input  logic             host_rec_i,
  input  logic             latch_clr_i,
  input  logic             tick15_i,
  input  logic             tick1s_i,
  output logic             alert_o,
  output logic             fault_o,
  output logic             latched_o,
  output logic             dsg_off_o,
  output logic             chg_off_o
);
  localparam int TW = MAX_CODE;
  localparam int QW = $clog2(QUIET_S + 1);

  logic [1:0]       sync_q;
  logic             fault_q, latched_q;
  logic [TW-1:0]    dly_cnt;
  logic [7:0]       rec_cnt;
  logic [CNT_W-1:0] lat_cnt;
  logic [QW-1:0]    quiet_cnt;

  wire cmp_s = sync_q[1];
  wire arming = en_i & cmp_s & ~fault_q;

  logic [CODE_W-1:0] code_eff;
  logic [TW-1:0]     last_tick;
  always_comb begin
    code_eff = (dly_code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : dly_code_i;
    last_tick = (code_eff == '0) ? '0 : ((TW'(1) << (code_eff - 1'b1)) - 1'b1);
  end

  wire trip = arming & ((code_eff == '0) | (tick15_i & (dly_cnt == last_tick)));

  wire [CNT_W-1:0] lat_inc = (lat_cnt == '1) ? lat_cnt : lat_cnt + 1'b1;

  wire timed_rec = (rec_time_i != 8'd0) & ~cmp_s & tick1s_i & (rec_cnt == rec_time_i - 8'd1);
  wire host_rec  = (rec_time_i == 8'd0) & host_rec_i;
  wire rec_done  = fault_q & ~latched_q & (timed_rec | host_rec);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      sync_q    <= '0;
      fault_q   <= 1'b0;
      latched_q <= 1'b0;
      dly_cnt   <= '0;
      rec_cnt   <= '0;
      lat_cnt   <= '0;
      quiet_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], cmp_raw_i};

      if (!arming || trip)  dly_cnt <= '0;
      else if (tick15_i)    dly_cnt <= dly_cnt + 1'b1;

      if (trip)             fault_q <= 1'b1;
      else if (rec_done)    fault_q <= 1'b0;

      if (!fault_q || latched_q || cmp_s || rec_done) rec_cnt <= '0;
      else if (tick1s_i)                              rec_cnt <= rec_cnt + 1'b1;

      if (latch_clr_i) begin
        lat_cnt   <= '0;
        latched_q <= 1'b0;
        quiet_cnt <= '0;
      end else if (trip) begin
        lat_cnt   <= lat_inc;
        latched_q <= latched_q | (lat_inc >= latch_lim_i);
        quiet_cnt <= '0;
      end else if (fault_q) begin
        quiet_cnt <= '0;
      end else if (tick1s_i) begin
        if (quiet_cnt == QW'(QUIET_S - 1)) begin
          quiet_cnt <= '0;
          lat_cnt   <= '0;
        end else begin
          quiet_cnt <= quiet_cnt + 1'b1;
        end
      end
    end
  end

  assign alert_o   = arming;
  assign fault_o   = fault_q;
  assign latched_o = latched_q;
  assign dsg_off_o = latched_q | (fault_q & dsg_auto_i);
  assign chg_off_o = latched_q | (fault_q & chg_auto_i);
endmodule

// File: rtl/scp_fault_ctrl_chk.sv
module scp_fault_ctrl_chk (
  input logic clk,
  input logic rst_i,
  input logic en_i,
  input logic host_rec_i,
  input logic latch_clr_i,
  input logic tick1s_i,
  input logic alert_o,
  input logic fault_o,
  input logic latched_o,
  input logic dsg_off_o,
  input logic chg_off_o
);
  p_trip_needs_enable_r1: assert property (@(posedge clk) disable iff (rst_i)
    $rose(fault_o) |-> $past(en_i));

  p_trip_after_alert_r3: assert property (@(posedge clk) disable iff (rst_i)
    $rose(fault_o) |-> $past(alert_o));

  p_release_cause_r7: assert property (@(posedge clk) disable iff (rst_i)
    $fell(fault_o) |-> $past(tick1s_i || host_rec_i));

  p_latch_forces_off_r9: assert property (@(posedge clk) disable iff (rst_i)
    latched_o |-> (dsg_off_o && chg_off_o && fault_o));

  p_latch_sticks_r11: assert property (@(posedge clk) disable iff (rst_i)
    (latched_o && !latch_clr_i) |=> latched_o);
endmodule

bind scp_fault_ctrl scp_fault_ctrl_chk u_chk (
  .clk(clk), .rst_i(rst_i), .en_i(en_i), .host_rec_i(host_rec_i),
  .latch_clr_i(latch_clr_i), .tick1s_i(tick1s_i), .alert_o(alert_o),
  .fault_o(fault_o), .latched_o(latched_o), .dsg_off_o(dsg_off_o),
  .chg_off_o(chg_off_o)
);

// File: tb/scp_fault_ctrl_tb.sv
`timescale 1ns/1ps
module scp_fault_ctrl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_i = 1'b1, cmp_raw_i = 1'b0, en_i = 1'b1;
  logic [3:0] dly_code_i = 4'd0;
  logic [7:0] rec_time_i = 8'd1;
  logic [3:0] latch_lim_i = 4'd15;
  logic dsg_auto_i = 1'b0, chg_auto_i = 1'b0, host_rec_i = 1'b0, latch_clr_i = 1'b0;
  logic tick15_i = 1'b0, tick1s_i = 1'b0;
  logic alert_o, fault_o, latched_o, dsg_off_o, chg_off_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  scp_fault_ctrl u_dut (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_i = 1'b1; cmp_raw_i = 1'b0; en_i = 1'b1; dly_code_i = 4'd0;
    rec_time_i = 8'd1; latch_lim_i = 4'd15; dsg_auto_i = 1'b0; chg_auto_i = 1'b0;
    host_rec_i = 1'b0; latch_clr_i = 1'b0; tick15_i = 1'b0; tick1s_i = 1'b0;
    cyc(2);
    rst_i = 1'b0;
    cyc(1);
  endtask

  task automatic t15(input int n);
    for (int i = 0; i < n; i++) begin tick15_i = 1'b1; cyc(1); tick15_i = 1'b0; end
  endtask

  task automatic t1s(input int n);
    for (int i = 0; i < n; i++) begin tick1s_i = 1'b1; cyc(1); tick1s_i = 1'b0; end
  endtask

  task automatic raise(); cmp_raw_i = 1'b1; cyc(3); endtask
  task automatic drop();  cmp_raw_i = 1'b0; cyc(3); endtask

  task automatic t_reset();
    do_reset();
    chk("R2 reset alert", alert_o, 1'b0);
    chk("R6 reset fault", fault_o, 1'b0);
    chk("R9 reset latched", latched_o, 1'b0);
    chk("R6 reset dsg_off", dsg_off_o, 1'b0);
    chk("R6 reset chg_off", chg_off_o, 1'b0);
  endtask

  task automatic t_enable();
    do_reset();
    en_i = 1'b0;
    raise();
    chk("R1 alert disabled", alert_o, 1'b0);
    t15(4);
    chk("R1 fault disabled", fault_o, 1'b0);
    drop();
  endtask

  task automatic t_sync();
    do_reset();
    dly_code_i = 4'd3;
    cmp_raw_i = 1'b1; cyc(1);
    chk("R12 alert after 1 clk", alert_o, 1'b0);
    cyc(1);
    chk("R12 alert after 2 clk", alert_o, 1'b1);
    cmp_raw_i = 1'b0; cyc(1);
    chk("R12 alert holds 1 clk", alert_o, 1'b1);
    cyc(1);
    chk("R2 alert drops before trip", alert_o, 1'b0);
    chk("R2 no fault", fault_o, 1'b0);
  endtask

  task automatic t_code0();
    do_reset();
    rec_time_i = 8'd0; dsg_auto_i = 1'b1;
    cmp_raw_i = 1'b1; cyc(2);
    chk("R3 alert first sample", alert_o, 1'b1);
    chk("R3 no fault yet", fault_o, 1'b0);
    cyc(1);
    chk("R3 fault set", fault_o, 1'b1);
    chk("R3 alert cleared", alert_o, 1'b0);
    chk("R6 dsg_off", dsg_off_o, 1'b1);
    chk("R6 chg_off", chg_off_o, 1'b0);
    drop(); t1s(3);
    chk("R8 no timed recovery at 0", fault_o, 1'b1);
    host_rec_i = 1'b1; cyc(1); host_rec_i = 1'b0;
    chk("R8 host recovery", fault_o, 1'b0);
    chk("R6 dsg_off released", dsg_off_o, 1'b0);
  endtask

  task automatic t_code_n();
    do_reset();
    dly_code_i = 4'd3; rec_time_i = 8'd3; chg_auto_i = 1'b1;
    raise(); t15(3);
    chk("R4 code3 before 4 ticks", fault_o, 1'b0);
    t15(1);
    chk("R4 code3 at 4 ticks", fault_o, 1'b1);
    chk("R6 chg_off", chg_off_o, 1'b1);
    chk("R6 dsg_off", dsg_off_o, 1'b0);
    drop(); t1s(2);
    chk("R7 before T ticks", fault_o, 1'b1);
    host_rec_i = 1'b1; cyc(1); host_rec_i = 1'b0;
    chk("R8 host ignored", fault_o, 1'b1);
    t1s(1);
    chk("R7 cleared at T", fault_o, 1'b0);
  endtask

  task automatic t_restart();
    do_reset();
    dly_code_i = 4'd2; rec_time_i = 8'd3;
    raise(); t15(1); drop(); raise(); t15(1);
    chk("R4 window restarted", fault_o, 1'b0);
    t15(1);
    chk("R4 trip after restart", fault_o, 1'b1);
    drop(); t1s(2); raise(); drop(); t1s(2);
    chk("R7 recovery restarted", fault_o, 1'b1);
    t1s(1);
    chk("R7 cleared after restart", fault_o, 1'b0);
  endtask

  task automatic t_clamp();
    do_reset();
    dly_code_i = 4'd15;
    raise(); t15(511);
    chk("R4 clamp before 512", fault_o, 1'b0);
    t15(1);
    chk("R4 clamp at 512", fault_o, 1'b1);
  endtask

  task automatic t_latch();
    do_reset();
    latch_lim_i = 4'd2;
    raise();
    chk("R5 first trip", fault_o, 1'b1);
    chk("R5 count 1 below limit", latched_o, 1'b0);
    drop(); t1s(1);
    chk("R7 one-second recovery", fault_o, 0);
    raise();
    chk("R9 latched at limit", latched_o, 1'b1);
    chk("R9 dsg_off forced", dsg_off_o, 1'b1);
    chk("R9 chg_off forced", chg_off_o, 1'b1);
    drop(); t1s(3);
    chk("R9 no timed release", fault_o, 1'b1);
    rec_time_i = 8'd0;
    host_rec_i = 1'b1; cyc(1); host_rec_i = 1'b0;
    chk("R9 no host release", fault_o, 1'b1);
    rec_time_i = 8'd1;
    latch_clr_i = 1'b1; cyc(1); latch_clr_i = 1'b0;
    chk("R11 latch cleared", latched_o, 1'b0);
    t1s(1);
    chk("R11 normal recovery", fault_o, 1'b0);
    raise();
    chk("R11 counter cleared", latched_o, 1'b0);
  endtask

  task automatic t_quiet();
    do_reset();
    latch_lim_i = 4'd2;
    raise(); drop(); t1s(1); t1s(5); raise();
    chk("R10 counter cleared after 5 s", latched_o, 1'b0);
    drop(); t1s(1); raise();
    chk("R5 second trip latches", latched_o, 1'b1);
    do_reset();
    latch_lim_i = 4'd2;
    raise(); drop(); t1s(1); t1s(4); raise();
    chk("R10 counter kept after 4 s", latched_o, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enable();
    t_sync();
    t_code0();
    t_code_n();
    t_restart();
    t_clamp();
    t_latch();
    t_quiet();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule